// File: doc/BRIEF.md
# Overlapped Ramp Code Merger

This block turns raw two-phase column conversion results into linear output codes. Each raw word holds a coarse ramp index and a fine count taken against that ramp. Neighbouring ramps deliberately cover overlapping voltage spans, so the two fields cannot simply be concatenated. Instead, the block looks up a calibrated start code for the selected ramp, scales the fine count by that ramp's integer slope, removes a fixed overlap bias, and clamps the result to the output range.

A small write-only register file holds one signed start code and one slope selector per ramp, plus a mode field. In plain mode all ramps count with unit slope. In companding mode each ramp uses its own power-of-two slope, and the fine count is limited to half its range. A bypass mode passes single-slope results through untouched.

Words enter and leave on valid/ready streams through a two-stage pipeline with a fixed latency. The pipeline stalls fully under backpressure.

Top module: `ramp_code_merge`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1. The start code of ramp r is r*128, every slope selector is 0 and the mode is plain.
- R2: In plain mode (mode 0), out = start[c] + f - 64, where c = in_raw_i[10:8] and f = in_raw_i[7:0]. The slope selectors have no effect in this mode.
- R3: In companding mode (mode 1), out = start[c] + f[6:0] * 2^sel[c] - 64. Bit 7 of the fine count is ignored.
- R4: A result below 0 is output as 0.
- R5: A result above 1023 is output as 1023.
- R6: In bypass mode (mode 2), out = in_raw_i[9:0] unchanged. Bit 10 of the raw word is ignored.
- R7: A write with cfg_addr_i = {2'b00, r} sets start[r] to cfg_wdata_i[11:0], read as a two's complement value.
- R8: A write with cfg_addr_i = {2'b01, r} sets sel[r] to cfg_wdata_i[1:0], giving a slope multiplier of 1, 2, 4 or 8.
- R9: A write with cfg_addr_i = 5'b10000 sets the mode to cfg_wdata_i[1:0]. The value 3 is ignored and leaves the mode unchanged.
- R10: A word accepted at a clock edge appears on out_valid_o/out_code_o after the second following edge when out_ready_i is high. Words leave in order.
- R11: While out_valid_o is high and out_ready_i is low, out_code_o is held. With both stages full, in_ready_o is 0. No word is lost or repeated.
- R12: The configuration in effect at the edge where a word is accepted is the one used for that word. A later write does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register address |
| cfg_wdata_i | input | 12 | Register write data |
| in_valid_i | input | 1 | Raw word valid |
| in_ready_o | output | 1 | Raw word accepted when high with valid |
| in_raw_i | input | 11 | Raw word: coarse index [10:8], fine count [7:0] |
| out_valid_o | output | 1 | Linear code valid |
| out_ready_i | input | 1 | Downstream ready |
| out_code_o | output | 10 | Linear output code |

## Verification
The assertions assume that the producer holds in_valid_i and in_raw_i steady until the word is accepted. They also assume the consumer may drop out_ready_i at any cycle. The stall checks rest on that freedom, so the stimulus deliberately lowers out_ready_i with two words in flight. Configuration writes are normally placed only while the pipeline is empty. The one exception is a write issued right after a word is accepted, which exercises the sampling point of R12. The raw words are picked to land on both clamp edges and on the saturation boundary codes themselves.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN   = 2'd0,
    MODE_COMPAND = 2'd1,
    MODE_BYPASS  = 2'd2,
    MODE_RSVD    = 2'd3
  } rcm_mode_e;

  localparam logic [1:0] SEL_START = 2'b00;
  localparam logic [1:0] SEL_SLOPE = 2'b01;
  localparam logic [1:0] SEL_MODE  = 2'b10;
endpackage

// File: rtl/rcm_cfg_regs.sv
module rcm_cfg_regs
  import rcm_pkg::*;
#(
  parameter int N_RAMPS = 8,
  parameter int START_W = 12,
  parameter int SEL_W   = 2,
  parameter int FINE_W  = 8,
  localparam int IDX_W  = $clog2(N_RAMPS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [START_W-1:0]                  wdata_i,
  output logic [N_RAMPS-1:0][START_W-1:0]     start_tab_o,
  output logic [N_RAMPS-1:0][SEL_W-1:0]       sel_tab_o,
  output rcm_mode_e                           mode_o
);
  logic [1:0]       field;
  logic [IDX_W-1:0] idx;

  assign field = addr_i[ADDR_W-1 -: 2];
  assign idx   = addr_i[IDX_W-1:0];

  for (genvar r = 0; r < N_RAMPS; r++) begin : g_ramp
    localparam logic [START_W-1:0] START_RST = START_W'(r << (FINE_W - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_tab_o[r] <= START_RST;
        sel_tab_o[r]   <= '0;
      end else if (we_i && idx == IDX_W'(r)) begin
        if (field == SEL_START) start_tab_o[r] <= wdata_i;
        if (field == SEL_SLOPE) sel_tab_o[r]   <= wdata_i[SEL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_PLAIN;
    end else if (we_i && field == SEL_MODE && idx == '0 &&
                 wdata_i[1:0] != MODE_RSVD) begin
      mode_o <= rcm_mode_e'(wdata_i[1:0]);
    end
  end

  // R9: reserved encoding never reaches the mode register
  a_r9_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != MODE_RSVD);
endmodule

// File: rtl/rcm_scale_stage.sv
module rcm_scale_stage
  import rcm_pkg::*;
#(
  parameter int N_RAMPS = 8,
  parameter int START_W = 12,
  parameter int SEL_W   = 2,
  parameter int FINE_W  = 8,
  parameter int OUT_W   = 10,
  localparam int IDX_W  = $clog2(N_RAMPS),
  localparam int RAW_W  = IDX_W + FINE_W,
  localparam int PROD_W = FINE_W + (1 << SEL_W) - 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  output logic                            ready_o,
  input  logic [RAW_W-1:0]                raw_i,
  input  rcm_mode_e                       mode_i,
  input  logic [N_RAMPS-1:0][START_W-1:0] start_tab_i,
  input  logic [N_RAMPS-1:0][SEL_W-1:0]   sel_tab_i,
  output logic                            valid_o,
  input  logic                            ready_i,
  output logic                            byp_o,
  output logic [OUT_W-1:0]                byp_code_o,
  output logic [START_W-1:0]              start_o,
  output logic [PROD_W-1:0]               prod_o
);
  logic [IDX_W-1:0]  coarse;
  logic [FINE_W-1:0] fine, fine_eff;
  logic [SEL_W-1:0]  shift;
  logic              compand;
  logic [PROD_W-1:0] prod_n;

  assign coarse  = raw_i[RAW_W-1:FINE_W];
  assign fine    = raw_i[FINE_W-1:0];
  assign compand = (mode_i == MODE_COMPAND);

  always_comb begin
    // companding halves the fine range: top fine bit dropped
    fine_eff = compand ? {1'b0, fine[FINE_W-2:0]} : fine;
    shift    = compand ? sel_tab_i[coarse] : '0;
    prod_n   = PROD_W'(fine_eff) << shift;
  end

  assign ready_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      byp_o      <= 1'b0;
      byp_code_o <= '0;
      start_o    <= '0;
      prod_o     <= '0;
    end else if (ready_o) begin
      valid_o <= valid_i;
      if (valid_i) begin
        byp_o      <= (mode_i == MODE_BYPASS);
        byp_code_o <= raw_i[OUT_W-1:0];
        start_o    <= start_tab_i[coarse];
        prod_o     <= prod_n;
      end
    end
  end

  a_r10_accept_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> valid_o);
  a_r11_ready_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ready_o);
endmodule

// File: rtl/rcm_merge_stage.sv
module rcm_merge_stage #(
  parameter int START_W      = 12,
  parameter int PROD_W       = 11,
  parameter int OUT_W        = 10,
  parameter int OVERLAP_BIAS = 64,
  localparam int SUM_W = ((START_W > PROD_W) ? START_W : PROD_W) + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  output logic               ready_o,
  input  logic               byp_i,
  input  logic [OUT_W-1:0]   byp_code_i,
  input  logic [START_W-1:0] start_i,
  input  logic [PROD_W-1:0]  prod_i,
  output logic               valid_o,
  input  logic               ready_i,
  output logic [OUT_W-1:0]   code_o
);
  localparam logic signed [SUM_W-1:0] BIAS_S = SUM_W'(OVERLAP_BIAS);
  localparam logic signed [SUM_W-1:0] MAX_S  = SUM_W'((1 << OUT_W) - 1);

  logic signed [SUM_W-1:0] start_x, prod_x, sum;
  logic [OUT_W-1:0]        code_n;

  always_comb begin
    start_x = {{(SUM_W-START_W){start_i[START_W-1]}}, start_i};
    prod_x  = {{(SUM_W-PROD_W){1'b0}}, prod_i};
    sum     = start_x + prod_x - BIAS_S;
    if (byp_i)                code_n = byp_code_i;
    else if (sum[SUM_W-1])    code_n = '0;
    else if (sum > MAX_S)     code_n = '1;
    else                      code_n = sum[OUT_W-1:0];
  end

  assign ready_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else if (ready_o) begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_n;
    end
  end

  a_r11_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(code_o));
  a_r10_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> valid_o);
endmodule

// File: rtl/ramp_code_merge.sv
module ramp_code_merge
  import rcm_pkg::*;
#(
  parameter int N_RAMPS      = 8,
  parameter int FINE_W       = 8,
  parameter int OUT_W        = 10,
  parameter int START_W      = 12,
  parameter int SEL_W        = 2,
  parameter int OVERLAP_BIAS = 64,
  localparam int IDX_W  = $clog2(N_RAMPS),
  localparam int RAW_W  = IDX_W + FINE_W,
  localparam int ADDR_W = IDX_W + 2,
  localparam int PROD_W = FINE_W + (1 << SEL_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [START_W-1:0] cfg_wdata_i,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [RAW_W-1:0]   in_raw_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [OUT_W-1:0]   out_code_o
);
  logic [N_RAMPS-1:0][START_W-1:0] start_tab;
  logic [N_RAMPS-1:0][SEL_W-1:0]   sel_tab;
  rcm_mode_e                       mode;

  logic               s1_valid, s2_ready, s1_byp;
  logic [OUT_W-1:0]   s1_byp_code;
  logic [START_W-1:0] s1_start;
  logic [PROD_W-1:0]  s1_prod;

  rcm_cfg_regs #(
    .N_RAMPS(N_RAMPS), .START_W(START_W), .SEL_W(SEL_W), .FINE_W(FINE_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .start_tab_o(start_tab), .sel_tab_o(sel_tab), .mode_o(mode)
  );

  rcm_scale_stage #(
    .N_RAMPS(N_RAMPS), .START_W(START_W), .SEL_W(SEL_W),
    .FINE_W(FINE_W), .OUT_W(OUT_W)
  ) u_scale (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .ready_o(in_ready_o), .raw_i(in_raw_i),
    .mode_i(mode), .start_tab_i(start_tab), .sel_tab_i(sel_tab),
    .valid_o(s1_valid), .ready_i(s2_ready),
    .byp_o(s1_byp), .byp_code_o(s1_byp_code), .start_o(s1_start), .prod_o(s1_prod)
  );

  rcm_merge_stage #(
    .START_W(START_W), .PROD_W(PROD_W), .OUT_W(OUT_W), .OVERLAP_BIAS(OVERLAP_BIAS)
  ) u_merge (
    .clk_i, .rst_ni,
    .valid_i(s1_valid), .ready_o(s2_ready),
    .byp_i(s1_byp), .byp_code_i(s1_byp_code), .start_i(s1_start), .prod_i(s1_prod),
    .valid_o(out_valid_o), .ready_i(out_ready_i), .code_o(out_code_o)
  );
endmodule

// File: tb/sim_ramp_code_merge.sv
`timescale 1ns/1ps
module sim_ramp_code_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] in_raw = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [9:0]  out_code;

  int checks = 0;
  int errors = 0;
  int m_start[8];
  int m_sel[8];
  int m_mode = 0;

  always #2.5 clk = ~clk;

  ramp_code_merge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_raw_i(in_raw),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_code_o(out_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int raw);
    int c, f, v;
    c = (raw >> 8) & 7;
    f = raw & 255;
    if (m_mode == 2) return raw & 1023;
    if (m_mode == 1) v = m_start[c] + (f & 127) * (1 << m_sel[c]) - 64;
    else             v = m_start[c] + f - 64;
    if (v < 0) v = 0;
    if (v > 1023) v = 1023;
    return v;
  endfunction

  task automatic cfg_write(input logic [4:0] a, input logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a[4:3] == 2'b00) m_start[a[2:0]] = (d >= 12'd2048) ? int'(d) - 4096 : int'(d);
    else if (a[4:3] == 2'b01) m_sel[a[2:0]] = int'(d[1:0]);
    else if (a == 5'b10000 && d[1:0] != 2'd3) m_mode = int'(d[1:0]);
  endtask

  // single word through an empty pipeline, checks latency (R10) and value
  task automatic xfer(input string req, input logic [10:0] raw, input int exp);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_raw = raw;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 no output one edge after accept", int'(out_valid), 0);
    @(negedge clk);
    check("R10 output two edges after accept", int'(out_valid), 1);
    check(req, int'(out_code), exp);
  endtask

  task automatic t_reset;
    check("R1 out_valid at reset", int'(out_valid), 0);
    check("R1 in_ready at reset", int'(in_ready), 1);
    xfer("R1 reset start code ramp 6", {3'd6, 8'd64}, 768);
  endtask

  task automatic t_plain;
    xfer("R2 plain c2 f100", {3'd2, 8'd100}, 292);
    cfg_write(5'b01_010, 12'd2);
    xfer("R2 slope ignored in plain", {3'd2, 8'd100}, 292);
    xfer("R2 plain c4 f200", {3'd4, 8'd200}, model({3'd4, 8'd200}));
  endtask

  task automatic t_sat;
    xfer("R4 below zero", {3'd0, 8'd10}, 0);
    xfer("R4 exact zero", {3'd0, 8'd64}, 0);
    xfer("R4 first step", {3'd0, 8'd65}, 1);
    xfer("R5 above max", {3'd7, 8'd255}, 1023);
    xfer("R5 exact max", {3'd7, 8'd191}, 1023);
    xfer("R5 below max", {3'd7, 8'd190}, 1022);
  endtask

  task automatic t_compand;
    cfg_write(5'b10000, 12'd1);
    xfer("R3 compand slope 4", {3'd2, 8'd100}, 592);
    xfer("R3 fine bit7 ignored", {3'd2, 8'd228}, 592);
    xfer("R3 compand slope 1", {3'd1, 8'd50}, 114);
    cfg_write(5'b01_101, 12'd3);
    xfer("R8 slope 8 ramp 5", {3'd5, 8'd20}, model({3'd5, 8'd20}));
    xfer("R5 compand clamp", {3'd5, 8'd127}, 1023);
  endtask

  task automatic t_start_write;
    cfg_write(5'b10000, 12'd0);
    cfg_write(5'b00_000, 12'hF9C); // -100
    xfer("R7 negative start", {3'd0, 8'd200}, 36);
    cfg_write(5'b00_101, 12'd1000);
    xfer("R7 positive start", {3'd5, 8'd30}, 966);
  endtask

  task automatic t_mode_illegal;
    cfg_write(5'b10000, 12'd3);
    xfer("R9 mode 3 ignored", {3'd2, 8'd228}, 420);
  endtask

  task automatic t_bypass;
    cfg_write(5'b10000, 12'd2);
    xfer("R6 bypass bit10 ignored", {3'b110, 8'h5A}, 10'h25A);
    xfer("R6 bypass all ones", {3'd7, 8'hFF}, 10'h3FF);
    cfg_write(5'b10000, 12'd0);
  endtask

  task automatic t_backpressure;
    int e0, e1, e2;
    e0 = model({3'd1, 8'd90});
    e1 = model({3'd3, 8'd140});
    e2 = model({3'd6, 8'd70});
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_raw = {3'd1, 8'd90};
    @(negedge clk);
    in_raw = {3'd3, 8'd140};
    @(negedge clk);
    in_raw = {3'd6, 8'd70};
    check("R11 first word out", int'(out_code), e0);
    check("R11 stall in_ready low", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    check("R11 held valid", int'(out_valid), 1);
    check("R11 held code", int'(out_code), e0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second word", int'(out_code), e1);
    @(negedge clk);
    check("R11 third word", int'(out_code), e2);
    check("R11 third valid", int'(out_valid), 1);
    @(negedge clk);
    check("R11 no duplicate", int'(out_valid), 0);
  endtask

  task automatic t_snapshot;
    int e_old;
    e_old = model({3'd3, 8'd100});
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_raw = {3'd3, 8'd100};
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = 5'b00_011; cfg_wdata = 12'd500;
    @(negedge clk);
    cfg_we = 1'b0;
    m_start[3] = 500;
    check("R12 in-flight word uses old start", int'(out_code), e_old);
    xfer("R12 next word uses new start", {3'd3, 8'd100}, 536);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) begin
      m_start[r] = r * 128;
      m_sel[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_sat();
    t_compand();
    t_start_write();
    t_mode_illegal();
    t_bypass();
    t_backpressure();
    t_snapshot();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule